// File: doc/BRIEF.md
# Protection region descriptor bank

This block keeps a parameterised set of memory-protection region descriptors and judges the accesses of one bus master against them. Software programs each descriptor through a plain register port: four 32-bit words per descriptor hold a start bound, an end bound, the access rights and a tag word that carries the descriptor's valid flag. The hardware keeps a descriptor coherent while it is being rewritten. A store to any of the first three words drops that descriptor's valid flag, and the descriptor stays out of use until the tag word is written again. A second, alias address for each descriptor's rights word lets software change permissions alone without disturbing validity.

On the access side the master presents an address, an access kind (read, write or execute) and its privilege level. Every valid descriptor whose inclusive bounds cover the address is a hit. A hit grants the access if its rights allow that kind at that privilege level. The access is flagged as an error only when no hit grants it. The error flag and the vector of hits are registered and appear one cycle after the request.

Top module: `prot_region_bank`

## Requirements
- R1: After reset every descriptor is invalid and every register word reads zero. `acc_err` and `hit_vec` are low, and any request made then returns `acc_err`=1 with an all-zero `hit_vec`.
- R2: Word w (0..3) of descriptor r is at byte offset 0x400 + 16*r + 4*w. Words 0 and 1 keep bits [31:5] and read back with bits [4:0] as zero. Word 2 reads back all 32 bits. Word 3 reads back bits [31:16] as written, bits [15:1] as zero and bit 0 as the valid flag.
- R3: A write to word 0, 1 or 2 of a descriptor clears that descriptor's valid flag.
- R4: A write to word 3 sets the valid flag to bit 0 of the written data.
- R5: Alias offset 0x800 + 4*r writes word 2 of descriptor r and leaves its valid flag unchanged. A read of the alias returns word 2.
- R6: A descriptor covers a request when start[31:5] <= req_addr[31:5] <= end[31:5], with both bounds inclusive.
- R7: In user mode (`req_super`=0) the rights are word 2 bits [2:0]: bit 2 read, bit 1 write, bit 0 execute. A set bit allows that kind.
- R8: In supervisor mode the rights come from word 2 bits [4:3]. 00 gives read/write/execute, 01 gives read/execute, 10 gives read/write, and 11 uses the user bits [2:0].
- R9: `acc_err` is set only when no valid covering descriptor grants the request. Grants of overlapping descriptors combine by OR, and invalid descriptors never hit or grant.
- R10: `acc_err` and `hit_vec` are registered one cycle after a cycle with `req_valid`=1. After a cycle with `req_valid`=0 both are zero. `hit_vec` bit r marks a valid descriptor r that covers the address, whatever its rights.
- R11: `req_kind` encodes 00 read, 01 write and 10 execute. The code 11 is never granted.
- R12: Writes to unmapped or misaligned offsets change nothing, and reads of them return zero. `reg_rdata` updates one cycle after `reg_rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | REG_AW | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| req_valid | input | 1 | Access request present |
| req_addr | input | 32 | Access address |
| req_kind | input | 2 | Access kind: 00 read, 01 write, 10 execute |
| req_super | input | 1 | 1 for supervisor, 0 for user |
| acc_err | output | 1 | Registered access-error pulse |
| hit_vec | output | NUM_DESC | Registered vector of valid covering descriptors |

## Verification
The assertions assume a single register port: a write and a read may share a cycle, but only one write is decoded per cycle. They also assume that the request inputs are stable and known whenever `req_valid` is high. The stimulus drives every input at the falling edge and holds it for a full cycle. It issues one register operation or one request per task call, so these assumptions always hold. Random bounds and addresses are kept inside a 64 KiB window, so descriptors overlap often and cover both inclusive edges. Random register offsets also reach the unmapped and misaligned space around the two windows.

// File: rtl/prb_pkg.sv
package prb_pkg;
  localparam int ADDR_W  = 32;
  localparam int DATA_W  = 32;
  localparam int GRAN_LSB = 5;
  localparam int BOUND_W = ADDR_W - GRAN_LSB;
  localparam int TAG_W   = 8;

  typedef enum logic [1:0] {
    KIND_READ  = 2'b00,
    KIND_WRITE = 2'b01,
    KIND_EXEC  = 2'b10,
    KIND_NONE  = 2'b11
  } acc_kind_e;

  typedef struct packed {
    logic [BOUND_W-1:0] lo_bound;
    logic [BOUND_W-1:0] hi_bound;
    logic [DATA_W-1:0]  rights;
    logic [TAG_W-1:0]   tag;
    logic [TAG_W-1:0]   tag_mask;
    logic               valid;
  } region_t;

  // Supervisor 2-bit code to {r,w,x}; code 3 defers to the user bits.
  function automatic logic [2:0] sup_rwx(input logic [1:0] code, input logic [2:0] usr);
    case (code)
      2'b00:   sup_rwx = 3'b111;
      2'b01:   sup_rwx = 3'b101;
      2'b10:   sup_rwx = 3'b110;
      default: sup_rwx = usr;
    endcase
  endfunction

  function automatic logic kind_ok(input logic [2:0] rwx, input logic [1:0] kind);
    case (kind)
      KIND_READ:  kind_ok = rwx[2];
      KIND_WRITE: kind_ok = rwx[1];
      KIND_EXEC:  kind_ok = rwx[0];
      default:    kind_ok = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/prb_regfile.sv
module prb_regfile
  import prb_pkg::*;
#(
  parameter int NUM_DESC   = 8,
  parameter int REG_AW     = 12,
  parameter int DESC_BASE  = 'h400,
  parameter int ALIAS_BASE = 'h800
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic                      rd_en,
  input  logic [REG_AW-1:0]         addr,
  input  logic [DATA_W-1:0]         wdata,
  output logic [DATA_W-1:0]         rdata,
  output region_t [NUM_DESC-1:0]    regions
);
  localparam int IDX_W = (NUM_DESC > 1) ? $clog2(NUM_DESC) : 1;
  localparam logic [REG_AW-1:0] D_LO = REG_AW'(DESC_BASE);
  localparam logic [REG_AW-1:0] D_HI = REG_AW'(DESC_BASE + 16 * NUM_DESC);
  localparam logic [REG_AW-1:0] A_LO = REG_AW'(ALIAS_BASE);
  localparam logic [REG_AW-1:0] A_HI = REG_AW'(ALIAS_BASE + 4 * NUM_DESC);

  logic [REG_AW-1:0] d_rel, a_rel;
  logic              in_desc, in_alias;
  logic [IDX_W-1:0]  d_idx, a_idx;
  logic [1:0]        d_word;
  logic              aligned;

  assign aligned  = (addr[1:0] == 2'b00);
  assign d_rel    = addr - D_LO;
  assign a_rel    = addr - A_LO;
  assign in_desc  = aligned && (addr >= D_LO) && (addr < D_HI);
  assign in_alias = aligned && (addr >= A_LO) && (addr < A_HI);
  assign d_idx    = d_rel[IDX_W+3:4];
  assign d_word   = d_rel[3:2];
  assign a_idx    = a_rel[IDX_W+1:2];

  logic unused_rel;
  assign unused_rel = ^{d_rel[REG_AW-1:IDX_W+4], d_rel[1:0], a_rel[REG_AW-1:IDX_W+2], a_rel[1:0]};

  genvar r;
  generate
    for (r = 0; r < NUM_DESC; r++) begin : g_desc
      region_t d_q;
      logic    hit_d, hit_a;
      assign hit_d = wr_en && in_desc  && (d_idx == IDX_W'(r));
      assign hit_a = wr_en && in_alias && (a_idx == IDX_W'(r));

      always_ff @(posedge clk) begin
        if (rst) begin
          d_q <= '0;
        end else if (hit_d) begin
          case (d_word)
            2'd0: begin d_q.lo_bound <= wdata[DATA_W-1:GRAN_LSB]; d_q.valid <= 1'b0; end
            2'd1: begin d_q.hi_bound <= wdata[DATA_W-1:GRAN_LSB]; d_q.valid <= 1'b0; end
            2'd2: begin d_q.rights   <= wdata;                    d_q.valid <= 1'b0; end
            default: begin
              d_q.tag      <= wdata[31:24];
              d_q.tag_mask <= wdata[23:16];
              d_q.valid    <= wdata[0];
            end
          endcase
        end else if (hit_a) begin
          d_q.rights <= wdata;
        end
      end
      assign regions[r] = d_q;
    end
  endgenerate

  logic [DATA_W-1:0] rd_mux;
  region_t           d_sel, a_sel;
  assign d_sel = regions[d_idx];
  assign a_sel = regions[a_idx];

  always_comb begin
    rd_mux = '0;
    if (in_desc) begin
      case (d_word)
        2'd0:    rd_mux = {d_sel.lo_bound, {GRAN_LSB{1'b0}}};
        2'd1:    rd_mux = {d_sel.hi_bound, {GRAN_LSB{1'b0}}};
        2'd2:    rd_mux = d_sel.rights;
        default: rd_mux = {d_sel.tag, d_sel.tag_mask, 15'b0, d_sel.valid};
      endcase
    end else if (in_alias) begin
      rd_mux = a_sel.rights;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  // R3
  partial_write_invalidates_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && in_desc && d_word != 2'd3) |=> !regions[$past(d_idx)].valid);

  // R4
  tag_write_sets_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && in_desc && d_word == 2'd3) |=> (regions[$past(d_idx)].valid == $past(wdata[0])));

  // R5
  alias_keeps_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && in_alias) |=> (regions[$past(a_idx)].valid == $past(regions[a_idx].valid)));

  // R12
  unmapped_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !in_desc && !in_alias) |=> $stable(regions));
endmodule

// File: rtl/prb_region_eval.sv
module prb_region_eval
  import prb_pkg::*;
#(
  parameter int NUM_DESC = 8
) (
  input  region_t [NUM_DESC-1:0] regions,
  input  logic [ADDR_W-1:0]      req_addr,
  input  logic [1:0]             req_kind,
  input  logic                   req_super,
  output logic [NUM_DESC-1:0]    hits,
  output logic [NUM_DESC-1:0]    grants
);
  logic [BOUND_W-1:0] blk;
  assign blk = req_addr[ADDR_W-1:GRAN_LSB];

  genvar r;
  generate
    for (r = 0; r < NUM_DESC; r++) begin : g_eval
      logic       covers;
      logic [2:0] rwx;
      logic       unused_bits;
      assign covers = (blk >= regions[r].lo_bound) && (blk <= regions[r].hi_bound);
      assign hits[r] = regions[r].valid && covers;
      assign rwx = req_super ? sup_rwx(regions[r].rights[4:3], regions[r].rights[2:0])
                             : regions[r].rights[2:0];
      assign grants[r] = hits[r] && kind_ok(rwx, req_kind);
      assign unused_bits = ^{regions[r].rights[DATA_W-1:5], regions[r].tag, regions[r].tag_mask};
    end
  endgenerate

  logic unused_lsb;
  assign unused_lsb = ^req_addr[GRAN_LSB-1:0];
endmodule

// File: rtl/prot_region_bank.sv
module prot_region_bank
  import prb_pkg::*;
#(
  parameter int NUM_DESC = 8,
  parameter int REG_AW   = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 reg_wr_en,
  input  logic                 reg_rd_en,
  input  logic [REG_AW-1:0]    reg_addr,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  input  logic                 req_valid,
  input  logic [31:0]          req_addr,
  input  logic [1:0]           req_kind,
  input  logic                 req_super,
  output logic                 acc_err,
  output logic [NUM_DESC-1:0]  hit_vec
);
  region_t [NUM_DESC-1:0] regions;
  logic    [NUM_DESC-1:0] hits, grants;

  prb_regfile #(.NUM_DESC(NUM_DESC), .REG_AW(REG_AW)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (reg_wr_en),
    .rd_en   (reg_rd_en),
    .addr    (reg_addr),
    .wdata   (reg_wdata),
    .rdata   (reg_rdata),
    .regions (regions)
  );

  prb_region_eval #(.NUM_DESC(NUM_DESC)) u_eval (
    .regions   (regions),
    .req_addr  (req_addr),
    .req_kind  (req_kind),
    .req_super (req_super),
    .hits      (hits),
    .grants    (grants)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_err <= 1'b0;
      hit_vec <= '0;
    end else begin
      acc_err <= req_valid && (grants == '0);
      hit_vec <= req_valid ? hits : '0;
    end
  end

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!acc_err && hit_vec == '0));

  // R9
  granted_no_err_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && grants != '0) |=> !acc_err);

  // R9
  no_hit_err_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && hits == '0) |=> (acc_err && hit_vec == '0));

  // R11
  kind_none_err_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_kind == 2'b11) |=> acc_err);
endmodule

// File: tb/tb_prot_region_bank.sv
module tb_prot_region_bank;
  localparam int N  = 8;
  localparam int AW = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          reg_wr_en = 1'b0, reg_rd_en = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          req_valid = 1'b0;
  logic [31:0]   req_addr = '0;
  logic [1:0]    req_kind = 2'b00;
  logic          req_super = 1'b0;
  logic          acc_err;
  logic [N-1:0]  hit_vec;

  int total = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  prot_region_bank #(.NUM_DESC(N), .REG_AW(AW)) dut (.*);

  // reference state
  logic [26:0] m_lo [N];
  logic [26:0] m_hi [N];
  logic [31:0] m_rt [N];
  logic [15:0] m_tg [N];
  logic        m_v  [N];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic bit is_desc(input logic [AW-1:0] a);
    return a[1:0] == 0 && a >= 12'h400 && a < 12'h400 + 16 * N;
  endfunction
  function automatic bit is_alias(input logic [AW-1:0] a);
    return a[1:0] == 0 && a >= 12'h800 && a < 12'h800 + 4 * N;
  endfunction

  function automatic void m_write(input logic [AW-1:0] a, input logic [31:0] d);
    if (is_desc(a)) begin
      int i = int'((a - 12'h400) >> 4);
      int w = int'(a[3:2]);
      case (w)
        0: begin m_lo[i] = d[31:5]; m_v[i] = 0; end
        1: begin m_hi[i] = d[31:5]; m_v[i] = 0; end
        2: begin m_rt[i] = d;       m_v[i] = 0; end
        default: begin m_tg[i] = d[31:16]; m_v[i] = d[0]; end
      endcase
    end else if (is_alias(a)) begin
      m_rt[int'((a - 12'h800) >> 2)] = d;
    end
  endfunction

  function automatic logic [31:0] m_read(input logic [AW-1:0] a);
    if (is_desc(a)) begin
      int i = int'((a - 12'h400) >> 4);
      case (a[3:2])
        2'd0: return {m_lo[i], 5'b0};
        2'd1: return {m_hi[i], 5'b0};
        2'd2: return m_rt[i];
        default: return {m_tg[i], 15'b0, m_v[i]};
      endcase
    end
    if (is_alias(a)) return m_rt[int'((a - 12'h800) >> 2)];
    return 32'h0;
  endfunction

  function automatic logic [N:0] m_eval(input logic [31:0] a, input logic [1:0] k, input logic s);
    logic [N-1:0] h = '0;
    logic g = 0;
    for (int i = 0; i < N; i++) begin
      logic [2:0] p;
      logic ok;
      h[i] = m_v[i] && a[31:5] >= m_lo[i] && a[31:5] <= m_hi[i];
      if (!s) p = m_rt[i][2:0];
      else case (m_rt[i][4:3])
        2'b00: p = 3'b111;
        2'b01: p = 3'b101;
        2'b10: p = 3'b110;
        default: p = m_rt[i][2:0];
      endcase
      ok = (k == 2'b00) ? p[2] : (k == 2'b01) ? p[1] : (k == 2'b10) ? p[0] : 1'b0;
      g |= h[i] & ok;
    end
    return {~g, h};
  endfunction

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 0;
    m_write(a, d);
  endtask

  task automatic rd(input logic [AW-1:0] a, input string req);
    @(negedge clk);
    reg_rd_en = 1; reg_addr = a;
    @(negedge clk);
    reg_rd_en = 0;
    chk(req, reg_rdata, m_read(a));
  endtask

  task automatic acc(input logic [31:0] a, input logic [1:0] k, input logic s, input string req);
    logic [N:0] e;
    @(negedge clk);
    req_valid = 1; req_addr = a; req_kind = k; req_super = s;
    @(negedge clk);
    req_valid = 0;
    e = m_eval(a, k, s);
    chk({req, " err"}, {31'b0, acc_err}, {31'b0, e[N]});
    chk({req, " hits"}, {{(32-N){1'b0}}, hit_vec}, {{(32-N){1'b0}}, e[N-1:0]});
  endtask

  function automatic logic [AW-1:0] da(input int r, input int w);
    return AW'(12'h400 + 16 * r + 4 * w);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; total++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'h5EED_0042);
    for (int i = 0; i < N; i++) begin
      m_lo[i] = '0; m_hi[i] = '0; m_rt[i] = '0; m_tg[i] = '0; m_v[i] = 0;
    end
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: reset state
    chk("R1 acc_err", {31'b0, acc_err}, 32'h0);
    chk("R1 hit_vec", {{(32-N){1'b0}}, hit_vec}, 32'h0);
    for (int r = 0; r < N; r++) rd(da(r, 3), "R1 word3 reset");
    acc(32'h0000_1000, 2'b00, 1'b1, "R1 empty bank");

    // R2: program descriptor 0, readback with masked bits
    wr(da(0, 0), 32'h0000_101F);
    wr(da(0, 1), 32'h0000_1FE0);
    wr(da(0, 2), 32'h0000_001C);
    wr(da(0, 3), 32'hAB0F_FFFF);
    rd(da(0, 0), "R2 word0");
    rd(da(0, 1), "R2 word1");
    rd(da(0, 2), "R2 word2");
    rd(da(0, 3), "R2 word3");
    chk("R2 word3 literal", m_read(da(0, 3)), 32'hAB0F_0001);

    // R6/R7: bounds and user rights (read only)
    acc(32'h0000_1000, 2'b00, 1'b0, "R6 low edge");
    acc(32'h0000_1FFF, 2'b00, 1'b0, "R6 high edge");
    acc(32'h0000_2000, 2'b00, 1'b0, "R6 above");
    acc(32'h0000_0FFF, 2'b00, 1'b0, "R6 below");
    acc(32'h0000_1800, 2'b01, 1'b0, "R7 write denied");
    acc(32'h0000_1800, 2'b10, 1'b0, "R7 exec denied");

    // R8/R5: all supervisor codes via alias, valid must stay set
    for (int c = 0; c < 4; c++) begin
      wr(AW'(12'h800), {27'b0, c[1:0], 3'b010});
      rd(da(0, 3), "R5 alias keeps valid");
      rd(AW'(12'h800), "R5 alias readback");
      for (int k = 0; k < 3; k++) acc(32'h0000_1840, k[1:0], 1'b1, "R8 supervisor code");
      acc(32'h0000_1840, 2'b01, 1'b0, "R7 user write");
    end

    // R3: partial writes invalidate
    for (int w = 0; w < 3; w++) begin
      wr(da(0, 3), 32'h0000_0001);
      wr(da(0, w), m_read(da(0, w)));
      rd(da(0, 3), "R3 valid cleared");
      acc(32'h0000_1000, 2'b00, 1'b1, "R3 invalid no grant");
    end
    // R4: word3 data bit sets / clears
    wr(da(0, 3), 32'h0000_0001);
    rd(da(0, 3), "R4 set");
    wr(da(0, 3), 32'h1234_0000);
    rd(da(0, 3), "R4 clear");
    wr(da(0, 3), 32'h0000_0001);

    // R9: overlap OR of grants (desc0 read-only user, desc1 write-only user)
    wr(da(0, 2), 32'h0000_001C); wr(da(0, 3), 32'h1);
    wr(da(1, 0), 32'h0000_1800); wr(da(1, 1), 32'h0000_2FE0);
    wr(da(1, 2), 32'h0000_001A); wr(da(1, 3), 32'h1);
    acc(32'h0000_1900, 2'b00, 1'b0, "R9 overlap read");
    acc(32'h0000_1900, 2'b01, 1'b0, "R9 overlap write");
    acc(32'h0000_1900, 2'b10, 1'b0, "R9 overlap exec");

    // R11: reserved kind
    acc(32'h0000_1900, 2'b11, 1'b1, "R11 kind 11");

    // R10: idle cycle after request returns quiet outputs
    @(negedge clk);
    chk("R10 idle err", {31'b0, acc_err}, 32'h0);
    chk("R10 idle hits", {{(32-N){1'b0}}, hit_vec}, 32'h0);

    // R12: unmapped and misaligned writes/reads
    wr(AW'(12'h3FC), 32'hFFFF_FFFF);
    wr(AW'(12'h401), 32'hFFFF_FFFF);
    wr(AW'(12'h800 + 4 * N), 32'hFFFF_FFFF);
    rd(AW'(12'h3FC), "R12 unmapped read");
    rd(AW'(12'h802), "R12 misaligned read");
    for (int r = 0; r < 2; r++)
      for (int w = 0; w < 4; w++) rd(da(r, w), "R12 state untouched");

    // random mix
    for (int it = 0; it < 1500; it++) begin
      int op = $urandom_range(0, 9);
      int r  = $urandom_range(0, N - 1);
      int w  = $urandom_range(0, 3);
      if (op < 3) begin
        logic [31:0] d = $urandom;
        if (w < 2) d = {16'b0, d[15:0]};
        if (w == 3 && $urandom_range(0, 3) != 0) d[0] = 1'b1;
        wr(da(r, w), d);
      end else if (op == 3) begin
        wr(AW'(12'h800 + 4 * r), $urandom);
      end else if (op == 4) begin
        rd(AW'($urandom_range(12'h3F0, 12'h840)), "R2 random read");
      end else begin
        acc({16'b0, 16'($urandom)}, 2'($urandom_range(0, 3)), 1'($urandom), "R9 random access");
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule